// File: doc/BRIEF.md
# Serial EEPROM slave protocol engine

This block is the byte-level controller of a two-wire serial memory slave. A bus front end that is not part of this block reports start conditions, stop conditions and the rising and falling edges of the serial clock as one-cycle event pulses, along with the sampled data line. The engine turns these events into byte transfers. It checks the control byte against a fixed device type code and three strap inputs, collects a two-byte word address, and then either stores incoming data bytes or shifts stored bytes out. It asks for the data line to be pulled low whenever it acknowledges a byte or sends a zero bit.

On the memory side there are three connections. The first is a synchronous read port, where the data for the presented address is expected one clock later. The second is a one-byte write port into a page cache. The third is a busy input from the write-cycle timer. A stop condition that follows accepted write data sends a one-cycle commit pulse to that timer. While the timer reports busy, the engine acknowledges nothing.

Top module: `eeprom_slave_engine`

## Requirements
- R1: A control byte is acknowledged only if its bits 7..4 are 1010, its bits 3..1 equal `strap[2:0]`, and `busy` is low. Bit 0 is the direction bit and bits arrive MSB first.
- R2: After a control byte that is not acknowledged, `sda_pull` stays low for every following clock until the next start event.
- R3: Direction bit 1 begins a read of the byte at the current address. Direction bit 0 begins a write that expects address bytes.
- R4: In a write, the byte after the control byte supplies address bits 12..8 from its bits 4..0, and its bits 7..5 are ignored. The next byte supplies address bits 7..0. Both bytes are acknowledged.
- R5: Every data byte of a write is acknowledged and produces a one-cycle `mem_wr_en` pulse with the byte and the current address. The address then increments in its low 6 bits only, wrapping within the 64-byte page.
- R6: An acknowledge holds `sda_pull` high from the clock fall that ends bit 8 of the byte, through the whole ninth clock high, until the fall that ends that ninth clock.
- R7: While `busy` is high, no byte of any kind is acknowledged.
- R8: In a read, each byte comes from `mem_rd_data` for `mem_rd_addr` and is sent MSB first. `sda_pull` high means a 0 on the bus. A master acknowledge (data line low on the ninth clock) increments the full 13-bit address, with 0x1FFF wrapping to 0x0000.
- R9: If the master does not acknowledge a read byte, `sda_pull` stays low until the next start event.
- R10: A stop event after at least one accepted write data byte produces exactly one `wr_commit` pulse. A stop event with no such data produces none.
- R11: A start event in any state, including in the middle of a byte, releases `sda_pull` and restarts control byte reception.
- R12: After reset `sda_pull`, `mem_wr_en` and `wr_commit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-cycle pulse: start or repeated start seen |
| stop_evt | input | 1 | One-cycle pulse: stop seen |
| scl_rise | input | 1 | One-cycle pulse: serial clock went high |
| scl_fall | input | 1 | One-cycle pulse: serial clock went low |
| sda_in | input | 1 | Sampled level of the data line |
| strap | input | 3 | Device select strap pins |
| busy | input | 1 | Internal write cycle in progress |
| sda_pull | output | 1 | Request to pull the data line low |
| mem_rd_addr | output | 13 | Read port address (current pointer) |
| mem_rd_data | input | 8 | Read port data, one clock after the address |
| mem_wr_en | output | 1 | Page cache byte write strobe |
| mem_wr_addr | output | 13 | Page cache write address |
| mem_wr_data | output | 8 | Page cache write data |
| wr_commit | output | 1 | Pulse that starts the internal write cycle |

## Verification
Assertions check on every cycle that an acknowledge stays steady through the ninth clock and that no acknowledge is raised while busy. They also check that the muted state never pulls the line, that a start always returns the engine to control reception with the line released, that a commit only follows a stop, and how the pointer steps for page and sequential increments. Other behaviour can only be shown by the directed scenarios, because it depends on whole byte sequences: control code and strap matching, the ignored upper address bits, page wraparound of written addresses, read data order, the 0x1FFF to 0x0000 wrap, and whether a commit follows a stop.

// File: rtl/eep_slave_pkg.sv
package eep_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CTRL = 3'd1,
        ST_AHI  = 3'd2,
        ST_ALO  = 3'd3,
        ST_WDAT = 3'd4,
        ST_RDAT = 3'd5,
        ST_MUTE = 3'd6
    } eep_state_e;

    typedef struct packed {
        eep_state_e state;
        logic [3:0] bit_cnt;   // 0..7 data bits, 8 acknowledge slot
        logic       seen_rise; // a clock high occurred in this slot
        logic       go_read;   // control byte selected a read
        logic [7:0] rx;
        logic [7:0] tx;
        logic       pull;
        logic       wr_en;
        logic [7:0] wr_data;
        logic       pend;      // write data accepted since control
        logic       commit;
    } eep_regs_t;

endpackage

// File: rtl/eep_ctrl_match.sv
module eep_ctrl_match #(
    parameter int         CODE_W = 4,
    parameter int         SEL_W  = 3,
    parameter logic [3:0] CODE   = 4'b1010
) (
    input  logic [7:0]       ctrl_byte,
    input  logic [SEL_W-1:0] strap,
    output logic             hit,
    output logic             is_read
);
    localparam int SEL_LO = 1;
    localparam int SEL_HI = SEL_LO + SEL_W - 1;

    logic code_ok;
    logic sel_ok;

    always_comb begin
        code_ok = (ctrl_byte[7 -: CODE_W] == CODE[CODE_W-1:0]);
        sel_ok  = (ctrl_byte[SEL_HI:SEL_LO] == strap);
        hit     = code_ok && sel_ok;
        is_read = ctrl_byte[0];
    end
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              inc_page,
    input  logic              inc_full,
    input  logic [7:0]        byte_in,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - 8;

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [PAGE_W-1:0] page_low;
    logic              unused_hi_bits;

    assign unused_hi_bits = ^byte_in[7:HI_W];

    always_comb begin
        addr_d   = addr_q;
        page_low = addr_q[PAGE_W-1:0] + 1'b1;
        if (ld_hi) begin
            addr_d[ADDR_W-1:8] = byte_in[HI_W-1:0];
        end else if (ld_lo) begin
            addr_d[7:0] = byte_in;
        end else if (inc_page) begin
            addr_d = {addr_q[ADDR_W-1:PAGE_W], page_low};
        end else if (inc_full) begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    // R8: sequential step covers all address bits and wraps at the top
    a_r8_full_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full && !ld_hi && !ld_lo && !inc_page) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

    // R5: page step never touches the bits above the page
    a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !ld_hi && !ld_lo) |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/eeprom_slave_engine.sv
module eeprom_slave_engine
    import eep_slave_pkg::*;
#(
    parameter int         ADDR_W = 13,
    parameter int         PAGE_W = 6,
    parameter int         SEL_W  = 3,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic [SEL_W-1:0]  strap,
    input  logic              busy,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    output logic              wr_commit
);
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] ACK_SLOT = 4'd8;

    eep_regs_t         d, q;
    logic [ADDR_W-1:0] wr_addr_d, wr_addr_q;
    logic [ADDR_W-1:0] addr;
    logic              ctrl_hit, ctrl_rd;
    logic              ld_hi, ld_lo, inc_page, inc_full;

    eep_ctrl_match #(.CODE_W(4), .SEL_W(SEL_W), .CODE(DEV_CODE)) u_match (
        .ctrl_byte (q.rx),
        .strap     (strap),
        .hit       (ctrl_hit),
        .is_read   (ctrl_rd)
    );

    eep_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_hi    (ld_hi),
        .ld_lo    (ld_lo),
        .inc_page (inc_page),
        .inc_full (inc_full),
        .byte_in  (q.rx),
        .addr     (addr)
    );

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.commit  = 1'b0;
        wr_addr_d = wr_addr_q;
        ld_hi     = 1'b0;
        ld_lo     = 1'b0;
        inc_page  = 1'b0;
        inc_full  = 1'b0;

        if (start_evt) begin
            d.state     = ST_CTRL;
            d.bit_cnt   = '0;
            d.seen_rise = 1'b0;
            d.go_read   = 1'b0;
            d.pull      = 1'b0;
            d.pend      = 1'b0;
        end else if (stop_evt) begin
            d.commit    = q.pend && (q.state == ST_WDAT);
            d.state     = ST_IDLE;
            d.bit_cnt   = '0;
            d.seen_rise = 1'b0;
            d.go_read   = 1'b0;
            d.pull      = 1'b0;
            d.pend      = 1'b0;
        end else if (q.state == ST_IDLE || q.state == ST_MUTE) begin
            d.pull = 1'b0;
        end else if (scl_rise) begin
            d.seen_rise = 1'b1;
            if (q.bit_cnt < ACK_SLOT) begin
                d.rx = {q.rx[6:0], sda_in};
            end else if (q.state == ST_RDAT) begin
                if (!sda_in) inc_full = 1'b1;
                else         d.state  = ST_MUTE;
            end
        end else if (scl_fall && q.seen_rise) begin
            d.seen_rise = 1'b0;
            if (q.bit_cnt == LAST_BIT) begin
                d.bit_cnt = ACK_SLOT;
                d.pull    = 1'b0;
                if (q.state != ST_RDAT) begin
                    if (busy) begin
                        d.state = ST_MUTE;
                    end else begin
                        unique case (q.state)
                            ST_CTRL: begin
                                if (ctrl_hit) begin
                                    d.pull    = 1'b1;
                                    d.go_read = ctrl_rd;
                                    d.state   = ST_AHI;
                                end else begin
                                    d.state = ST_MUTE;
                                end
                            end
                            ST_AHI: begin
                                d.pull  = 1'b1;
                                ld_hi   = 1'b1;
                                d.state = ST_ALO;
                            end
                            ST_ALO: begin
                                d.pull  = 1'b1;
                                ld_lo   = 1'b1;
                                d.state = ST_WDAT;
                            end
                            ST_WDAT: begin
                                d.pull    = 1'b1;
                                d.wr_en   = 1'b1;
                                d.wr_data = q.rx;
                                wr_addr_d = addr;
                                inc_page  = 1'b1;
                                d.pend    = 1'b1;
                            end
                            default: d.state = ST_MUTE;
                        endcase
                    end
                end
            end else if (q.bit_cnt == ACK_SLOT) begin
                d.bit_cnt = '0;
                d.pull    = 1'b0;
                if (q.go_read || q.state == ST_RDAT) begin
                    d.state   = ST_RDAT;
                    d.go_read = 1'b0;
                    d.pull    = ~mem_rd_data[7];
                    d.tx      = {mem_rd_data[6:0], 1'b0};
                end
            end else begin
                d.bit_cnt = q.bit_cnt + 1'b1;
                if (q.state == ST_RDAT) begin
                    d.pull = ~q.tx[7];
                    d.tx   = {q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            wr_addr_q <= '0;
        end else begin
            q         <= d;
            wr_addr_q <= wr_addr_d;
        end
    end

    assign sda_pull    = q.pull;
    assign mem_rd_addr = addr;
    assign mem_wr_en   = q.wr_en;
    assign mem_wr_addr = wr_addr_q;
    assign mem_wr_data = q.wr_data;
    assign wr_commit   = q.commit;

    // R6: an acknowledge is held until the clock fall that closes the ninth pulse
    a_r6_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.bit_cnt == ACK_SLOT && q.pull && !scl_fall && !start_evt && !stop_evt) |=> q.pull);

    // R7: a byte completed while busy never raises the pull request
    a_r7_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && q.seen_rise && q.bit_cnt == LAST_BIT && busy && !start_evt && !stop_evt)
        |=> !q.pull);

    // R2 / R9: the muted state keeps the line released
    a_r2_mute_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_MUTE) |-> !q.pull);

    // R10: a commit pulse only follows a stop event
    a_r10_commit_src: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_evt));

    // R11: a start always returns to control reception with the line free
    a_r11_start_home: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (q.state == ST_CTRL && !q.pull));

    // R5: a page cache write strobe lasts a single cycle
    a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);
endmodule

// File: tb/test_eeprom_slave_engine.sv
module test_eeprom_slave_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_evt = 1'b0, stop_evt = 1'b0;
    logic        scl_rise = 1'b0, scl_fall = 1'b0;
    logic        sda_in = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        busy = 1'b0;
    logic        sda_pull;
    logic [12:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        mem_wr_en;
    logic [12:0] mem_wr_addr;
    logic [7:0]  mem_wr_data;
    logic        wr_commit;

    int errors = 0, checks = 0;
    int wr_n = 0, commit_n = 0;
    logic [12:0] wlog_a [0:15];
    logic [7:0]  wlog_d [0:15];
    logic        pull_seen = 1'b0;

    always #10 clk = ~clk;

    eeprom_slave_engine i_eeprom_slave_engine (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .strap(strap),
        .busy(busy), .sda_pull(sda_pull), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .wr_commit(wr_commit)
    );

    function automatic logic [7:0] rd_pattern(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    always @(posedge clk) mem_rd_data <= rd_pattern(mem_rd_addr);

    always @(negedge clk) begin
        if (sda_pull) pull_seen <= 1'b1;
        if (wr_commit) commit_n <= commit_n + 1;
        if (mem_wr_en && wr_n < 16) begin
            wlog_a[wr_n] <= mem_wr_addr;
            wlog_d[wr_n] <= mem_wr_data;
            wr_n <= wr_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // one clock pulse: pre = pull before the rise, mid = pull while high
    task automatic clk_bit(input logic b, output logic pre, output logic mid);
        @(negedge clk); sda_in = b; pre = sda_pull;
        @(negedge clk); scl_rise = 1'b1;
        @(negedge clk); scl_rise = 1'b0;
        repeat (2) @(negedge clk);
        mid = sda_pull;
        scl_fall = 1'b1;
        @(negedge clk); scl_fall = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_pre, output logic ack_mid);
        logic p, m;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], p, m);
        clk_bit(1'b1, ack_pre, ack_mid);
        sda_in = 1'b1;
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] v);
        logic p, m;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, p, m);
            v[i] = ~m;
        end
        clk_bit(~master_ack, p, m);
        sda_in = 1'b1;
    endtask

    task automatic t_reset();
        chk("R12 pull after reset", sda_pull, 0);
        chk("R12 wr_en after reset", mem_wr_en, 0);
        chk("R12 commit after reset", wr_commit, 0);
    endtask

    task automatic t_bad_code();
        logic p, m;
        bus_start();
        pull_seen = 1'b0;
        send_byte(8'b1011_1010, p, m);
        chk("R1 wrong code not acked", {p, m}, 2'b00);
        send_byte(8'b1010_1010, p, m);
        chk("R2 silent until next start", pull_seen, 0);
        bus_start();
        send_byte(8'b1010_0000, p, m);
        chk("R1 wrong strap not acked", {p, m}, 2'b00);
        bus_stop();
    endtask

    task automatic t_page_write();
        logic p, m;
        int base = wr_n;
        int c0 = commit_n;
        bus_start();
        send_byte(8'b1010_1010, p, m);
        chk("R1 matching write control acked", {p, m}, 2'b11);
        send_byte(8'hE1, p, m);
        chk("R4 high address acked", {p, m}, 2'b11);
        send_byte(8'h3E, p, m);
        chk("R4 low address acked", {p, m}, 2'b11);
        send_byte(8'hA5, p, m);
        chk("R6 ack held through ninth clock", {p, m}, 2'b11);
        chk("R6 ack released after slot", sda_pull, 0);
        send_byte(8'h5A, p, m);
        chk("R5 data acked", {p, m}, 2'b11);
        send_byte(8'h77, p, m);
        chk("R5 data acked after wrap", {p, m}, 2'b11);
        chk("R5 write count", wr_n - base, 3);
        chk("R4 first write address", wlog_a[base], 13'h013E);
        chk("R3 first write data", wlog_d[base], 8'hA5);
        chk("R5 second write address", wlog_a[base+1], 13'h013F);
        chk("R5 page wrap address", wlog_a[base+2], 13'h0100);
        chk("R5 wrapped data", wlog_d[base+2], 8'h77);
        chk("R10 no commit before stop", commit_n - c0, 0);
        bus_stop();
        chk("R10 one commit after stop", commit_n - c0, 1);
    endtask

    task automatic t_busy();
        logic p, m;
        busy = 1'b1;
        bus_start();
        pull_seen = 1'b0;
        send_byte(8'b1010_1010, p, m);
        chk("R7 no ack while busy", pull_seen, 0);
        bus_stop();
        busy = 1'b0;
    endtask

    task automatic t_seq_read();
        logic p, m;
        logic [7:0] v;
        int c0 = commit_n;
        bus_start();
        send_byte(8'b1010_1010, p, m);
        send_byte(8'h1F, p, m);
        send_byte(8'hFE, p, m);
        chk("R4 address bytes acked", {p, m}, 2'b11);
        bus_start();
        send_byte(8'b1010_1011, p, m);
        chk("R11 control after repeated start acked", {p, m}, 2'b11);
        read_byte(1'b1, v);
        chk("R3 read first byte", v, rd_pattern(13'h1FFE));
        read_byte(1'b1, v);
        chk("R8 read incremented byte", v, rd_pattern(13'h1FFF));
        read_byte(1'b0, v);
        chk("R8 read after wrap to zero", v, rd_pattern(13'h0000));
        pull_seen = 1'b0;
        for (int i = 0; i < 9; i++) clk_bit(1'b1, p, m);
        chk("R9 released after master nack", pull_seen, 0);
        bus_stop();
        chk("R10 no commit for read", commit_n - c0, 0);
    endtask

    task automatic t_mid_start();
        logic p, m;
        int c0 = commit_n;
        bus_start();
        for (int i = 0; i < 4; i++) clk_bit(1'b1, p, m);
        bus_start();
        send_byte(8'b1010_1010, p, m);
        chk("R11 start mid-byte resyncs", {p, m}, 2'b11);
        send_byte(8'h00, p, m);
        send_byte(8'h10, p, m);
        bus_stop();
        chk("R10 no commit without data", commit_n - c0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_bad_code();
        t_page_write();
        t_busy();
        t_seq_read();
        t_mid_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule